// File: doc/BRIEF.md
# Periodic Tick Down-Counter Timer

This block is a host-visible general-purpose timer. A prescaler divides the system clock into a fixed tick, nominally 100 µs. Each tick moves a 16-bit down-counter one step toward zero. When the counter passes through zero it rolls over to its all-ones value and keeps running. It does not return to the programmed start value. The rollover can raise a sticky interrupt flag, which drives a level interrupt request.

Software reaches the timer through a small register port: a write strobe with an address and data, and a combinational read path. The configuration register holds the run bit and the start value together, so a single write can set both. Software clears the interrupt flag by writing a one to it. A separate register holds the interrupt enable.

Top module: `tick_timer`

## Requirements
- R1: After reset, the start value and the count both read FFFFh, and the run bit, the interrupt flag, the interrupt enable and `irq` are all 0.
- R2: The register map is: address 0 holds the configuration (start value in bits 15:0, run bit at bit 16); address 1 holds the count in bits 15:0 and is read-only; address 2 holds the interrupt flag at bit 0; address 3 holds the interrupt enable at bit 0. Bits that are not defined read 0.
- R3: While running, the count falls by one once every `TICK_CYCLES` clock cycles, and never while stopped. The tick divider restarts on every load, so the first step comes a full `TICK_CYCLES` cycles after the load.
- R4: A configuration write that turns the run bit from 0 to 1 loads the count from the start value in that same write.
- R5: A configuration write that turns the run bit from 1 to 0 forces the stored start value to FFFFh and ignores the written value. While stopped, the count holds its value.
- R6: A configuration write made while stopped, with the run bit still 0, stores the written start value and leaves the count unchanged.
- R7: A configuration write made while running, with the run bit still 1, restarts the count from the newly written start value.
- R8: A tick that finds the count at 0000h sets the count to FFFFh and counting continues. The start value is not reloaded.
- R9: A rollover sets the interrupt flag only if the interrupt enable is 1 in the cycle of the rollover.
- R10: The interrupt flag is sticky. Writing 1 to bit 0 of address 2 clears it, and writing 0 has no effect. If a rollover that would set the flag and a clearing write fall in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when both the interrupt flag and the interrupt enable are 1. Clearing the enable drops `irq` but leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational from `rd_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check the following:
- the count loads on a rising run bit;
- the start value is restored when the run bit falls;
- the count holds while stopped;
- a tick steps the count down or rolls it over;
- ticks never occur while stopped;
- the interrupt flag is set only when the enable is 1, and stays set until a clearing write;
- `irq` is low whenever the enable is low.

Some behaviours depend on the exact cycles at which writes arrive, so only the bench scenarios can show them:
- a restart from a new value in the middle of a count;
- a clearing write that lands in the same cycle as a rollover;
- the full tick spacing after each load;
- values written while stopped being kept.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        REG_CFG    = 2'd0,
        REG_COUNT  = 2'd1,
        REG_STATUS = 2'd2,
        REG_IRQEN  = 2'd3
    } reg_addr_e;

    localparam int unsigned RUN_BIT  = 16;
    localparam int unsigned FLAG_BIT = 0;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int unsigned TICK_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned PS_W = $clog2(TICK_CYCLES + 1);
    localparam logic [PS_W-1:0] LAST = PS_W'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [PS_W-1:0] phase;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic      at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.phase == LAST);
        tick    = run && !restart && at_last;
        if (restart || !run) begin
            st_d.phase = '0;
        end else if (at_last) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tick_downcounter.sv
module tick_downcounter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.value == '0);
        wrap    = tick && !load && at_zero;
        if (load) begin
            st_d.value = load_val;
        end else if (tick) begin
            if (at_zero) begin
                st_d.value = '1;
            end else begin
                st_d.value = st_q.value - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.value <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.value;

endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic ie_wr,
    input  logic ie_val,
    input  logic clr_wr,
    input  logic clr_val,
    output logic flag,
    output logic ie,
    output logic irq
);
    typedef struct packed {
        logic flag;
        logic ie;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic       set_hit;
    logic       clr_hit;

    always_comb begin
        st_d    = st_q;
        set_hit = wrap && st_q.ie;
        clr_hit = clr_wr && clr_val;
        if (set_hit) begin
            st_d.flag = 1'b1;
        end else if (clr_hit) begin
            st_d.flag = 1'b0;
        end
        if (ie_wr) begin
            st_d.ie = ie_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign ie   = st_q.ie;
    assign irq  = st_q.flag && st_q.ie;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 10000,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int unsigned PAD_W = DATA_W - CNT_W - 1;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] start;
    } cfg_state_t;

    cfg_state_t       cfg_d, cfg_q;
    logic             cfg_wr;
    logic             load;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] count;
    logic             flag;
    logic             ie;
    logic             run_en;
    logic [CNT_W-1:0] start_val;

    always_comb begin
        cfg_d  = cfg_q;
        load   = 1'b0;
        cfg_wr = wr_en && (wr_addr == REG_CFG);
        if (cfg_wr) begin
            cfg_d.run = wr_data[RUN_BIT];
            if (wr_data[RUN_BIT]) begin
                cfg_d.start = wr_data[CNT_W-1:0];
                load        = 1'b1;
            end else if (cfg_q.run) begin
                cfg_d.start = '1;
            end else begin
                cfg_d.start = wr_data[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.run   <= 1'b0;
            cfg_q.start <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign run_en    = cfg_q.run;
    assign start_val = cfg_q.start;

    tick_prescaler #(
        .TICK_CYCLES(TICK_CYCLES)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_en),
        .restart(load),
        .tick   (tick)
    );

    tick_downcounter #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (load),
        .load_val(wr_data[CNT_W-1:0]),
        .count   (count),
        .wrap    (wrap)
    );

    tick_irq_ctrl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .ie_wr  (wr_en && (wr_addr == REG_IRQEN)),
        .ie_val (wr_data[FLAG_BIT]),
        .clr_wr (wr_en && (wr_addr == REG_STATUS)),
        .clr_val(wr_data[FLAG_BIT]),
        .flag   (flag),
        .ie     (ie),
        .irq    (irq)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            REG_CFG:    rd_data = {{PAD_W{1'b0}}, cfg_q.run, cfg_q.start};
            REG_COUNT:  rd_data = {{(DATA_W-CNT_W){1'b0}}, count};
            REG_STATUS: rd_data = {{(DATA_W-1){1'b0}}, flag};
            REG_IRQEN:  rd_data = {{(DATA_W-1){1'b0}}, ie};
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              run_en,
    input logic [CNT_W-1:0]  start_val,
    input logic [CNT_W-1:0]  count,
    input logic              tick,
    input logic              flag,
    input logic              ie,
    input logic              irq
);
    logic clr_hit;
    assign clr_hit = wr_en && (wr_addr == 2'd2) && wr_data[0];

    AST_LOAD_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> (count == start_val));                              // R4
    AST_START_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_en) |-> (start_val == '1));                                 // R5
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (run_en || $stable(count)));                              // R5
    AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !tick);                                                   // R3
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != '0) |=> (count == CNT_W'($past(count) - 1'b1)));    // R3
    AST_WRAP_TO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == '0) |=> (count == '1));                             // R8
    AST_FLAG_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(ie));                                           // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_hit) |=> flag);                                         // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq);                                                        // R11

endmodule

bind tick_timer tick_timer_chk #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .run_en   (run_en),
    .start_val(start_val),
    .count    (count),
    .tick     (tick),
    .flag     (flag),
    .ie       (ie),
    .irq      (irq)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    bit        m_run = 0;
    bit        m_flag = 0;
    bit        m_ie = 0;
    bit [15:0] m_start = 16'hFFFF;
    bit [15:0] m_cnt = 16'hFFFF;
    int        m_ps = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer #(.TICK_CYCLES(DIV), .CNT_W(16), .DATA_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    function automatic bit [31:0] exp_read(input bit [1:0] a);
        case (a)
            2'd0: return {15'd0, m_run, m_start};
            2'd1: return {16'd0, m_cnt};
            2'd2: return {31'd0, m_flag};
            default: return {31'd0, m_ie};
        endcase
    endfunction

    task automatic check(input string tag, input bit [1:0] ra);
        bit [31:0] er;
        bit        ei;
        er = exp_read(ra);
        ei = m_flag && m_ie;
        checks++;
        if (rd_data !== er || irq !== ei) begin
            errors++;
            $display("FAIL %s: addr %0d rd_data=%h irq=%b, expected rd_data=%h irq=%b",
                     tag, ra, rd_data, irq, er, ei);
        end
    endtask

    // one clock: drive, advance the reference, compare after the edge
    task automatic cycle(input bit we, input bit [1:0] a, input bit [31:0] d,
                         input bit [1:0] ra, input string tag);
        bit        n_run, n_flag, n_ie, wrapped, loaded;
        bit [15:0] n_start, n_cnt;
        int        n_ps;
        wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
        n_run = m_run; n_start = m_start; n_cnt = m_cnt; n_ps = m_ps;
        n_flag = m_flag; n_ie = m_ie; wrapped = 0; loaded = 0;
        if (we && a == 2'd0) begin
            n_run = d[16];
            if (d[16]) begin
                n_start = d[15:0]; n_cnt = d[15:0]; loaded = 1;
            end else if (m_run) n_start = 16'hFFFF;
            else n_start = d[15:0];
        end
        if (loaded || !m_run) n_ps = 0;
        else if (m_ps == DIV - 1) begin
            n_ps = 0;
            if (m_cnt == 0) begin n_cnt = 16'hFFFF; wrapped = 1; end
            else n_cnt = m_cnt - 1;
        end else n_ps = m_ps + 1;
        if (we && a == 2'd3) n_ie = d[0];
        if (we && a == 2'd2 && d[0]) n_flag = 0;
        if (wrapped && m_ie) n_flag = 1;
        @(posedge clk);
        #1;
        m_run = n_run; m_start = n_start; m_cnt = n_cnt; m_ps = n_ps;
        m_flag = n_flag; m_ie = n_ie;
        wr_en = 0;
        check(tag, ra);
    endtask

    task automatic idle(input int n, input bit [1:0] ra, input string tag);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, ra, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 / R2: reset values at every address
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #1; check("R1 R2 reset", 2'(a));
        end
        // R6: start value stored while stopped, count unchanged, R5 hold
        cycle(1, 0, 32'h0000_0003, 0, "R6 write while stopped");
        idle(8, 1, "R5 count holds while stopped");
        cycle(0, 0, 0, 0, "R6 start value kept");
        // R11: enable interrupt
        cycle(1, 3, 32'h1, 3, "R11 enable write");
        // R4 / R3 / R8 / R9: run from 3, rollover after four ticks
        cycle(1, 0, 32'h0001_0003, 1, "R4 load on enable");
        idle(DIV * 4 + 8, 1, "R3 R8 ticks and rollover");
        cycle(0, 0, 0, 2, "R9 flag set at rollover");
        cycle(0, 0, 0, 0, "R8 start value not reloaded");
        // R10: write 0 no effect, write 1 clears
        cycle(1, 2, 32'h0, 2, "R10 zero write ignored");
        cycle(1, 2, 32'h1, 2, "R10 one write clears");
        // R7: restart mid-count from new value
        idle(DIV + 2, 1, "R3 running");
        cycle(1, 0, 32'h0001_0007, 1, "R7 restart");
        idle(DIV * 3, 1, "R7 R3 count after restart");
        // R11: gate drops irq, flag stays
        cycle(1, 0, 32'h0001_0000, 1, "R7 restart at zero");
        idle(DIV + 1, 2, "R9 flag after rollover");
        cycle(1, 3, 32'h0, 2, "R11 disable gate keeps flag");
        cycle(0, 0, 0, 3, "R11 gate reads 0");
        // R9: rollover with enable off does not set flag
        cycle(1, 2, 32'h1, 2, "R10 clear");
        cycle(1, 0, 32'h0001_0001, 1, "R7 restart at one");
        idle(DIV * 3, 2, "R9 no flag without enable");
        // R10: clear and rollover in the same cycle, set wins
        cycle(1, 3, 32'h1, 3, "R11 enable again");
        cycle(1, 0, 32'h0001_0000, 1, "R7 restart at zero");
        while (!(m_ps == DIV - 1 && m_cnt == 0)) cycle(0, 0, 0, 1, "R3 approach");
        cycle(1, 2, 32'h1, 2, "R10 set wins over clear");
        // R5: stop forces start value to FFFF, count holds
        cycle(1, 0, 32'h0000_1234, 0, "R5 stop restores start");
        idle(DIV * 2, 1, "R5 count frozen");
        cycle(1, 2, 32'h1, 2, "R10 final clear");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule